// File: doc/BRIEF.md
# Video Picture Frame Border Inserter

This block paints a solid coloured rectangle (the picture frame) over an RGB pixel stream. Two counters track the position of the current pixel: a pixel index that restarts at every horizontal sync and a line index that restarts at every vertical sync. Four programmable 9-bit positions set a horizontal and a vertical window. The frame region is the part of the picture where both windows are active. A begin position larger than its end makes the window wrap around the edge of the line or field. Dedicated codes switch an axis off, and one code makes the window cover the whole line.

Inside the frame, each colour channel is replaced by a 4-bit frame colour component times (contrast code + 4), which gives an 8-bit amplitude. Outside the frame, the input video is passed through. Both paths have one cycle of latency. Settings are written through a plain address/data write port into shadow registers. They are copied into the working set on the next rising edge of vertical sync, so a field is never drawn with a mixture of old and new settings. Contrast codes above 13 are clamped to 13 and set a sticky error flag.

Top module: `pic_frame_insert`

## Requirements
- R1: The pixel index is the number of cycles with `pixValid` high since the last rising edge of `hsyncIn`. The line index is the number of rising edges of `hsyncIn` since the last rising edge of `vsyncIn`. A rising edge of `vsyncIn` clears both indices.
- R2: When an axis begin position B is not above its end position E, that axis is active for indices c with B <= c < E. If B equals E, the axis is never active.
- R3: When B is greater than E, the axis is active for c >= B or c < E.
- R4: A horizontal begin of 0 turns the horizontal window off. A vertical begin of 0 turns the vertical window off. Either one leaves the video unchanged.
- R5: A horizontal begin of 0x1FF makes every pixel of the line horizontally active, whatever the end value.
- R6: For a valid pixel inside both windows, `frameOut` is 1 one cycle later and each channel outputs colour × (contrast + 4). In every other case, `frameOut` is 0 and each channel outputs its input from one cycle earlier.
- R7: Contrast codes 14 and 15 produce the same amplitude as code 13.
- R8: Writing a contrast code of 14 or 15 sets `errFlag` on the next cycle. The flag stays set until reset.
- R9: A write changes the shadow registers only. The output follows the new value only after the next rising edge of `vsyncIn`.
- R10: The write address map is: 0 horizontal begin, 1 horizontal end, 2 vertical begin, 3 vertical end, 4/5/6 red/green/blue colour (4 bits), 7/8/9 red/green/blue contrast (4 bits). After reset the values are 0, 0, 270, 56, with colours and contrasts 0. After reset all outputs and `errFlag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| hsyncIn | input | 1 | Horizontal sync; its rising edge starts a new line |
| vsyncIn | input | 1 | Vertical sync; its rising edge starts a field and loads the settings |
| pixValid | input | 1 | High for cycles that carry an active pixel |
| rIn | input | 8 | Red input sample |
| gIn | input | 8 | Green input sample |
| bIn | input | 8 | Blue input sample |
| cfgWrEn | input | 1 | Write strobe for the settings |
| cfgAddr | input | 4 | Setting address (see R10) |
| cfgData | input | 9 | Write data; colour and contrast use bits 3:0 |
| rOut | output | 8 | Red output sample |
| gOut | output | 8 | Green output sample |
| bOut | output | 8 | Blue output sample |
| frameOut | output | 1 | High when the output sample is frame colour |
| errFlag | output | 1 | Sticky flag for an invalid contrast code |

## Verification
A wrong pixel or line index moves the edges of the frame. This shows at the ports as early as the first mismatching pixel of the affected line. The bench therefore compares every pixel of several fields against a position model, for plain, wrapped, disabled, full-line and empty windows. A working register loaded at the wrong moment shows as a frame change in the middle of a field, so settings are rewritten in the middle of a field and the remaining lines are checked against the old values. A broken contrast clamp or error flag shows as a wrong amplitude on the next valid pixel, or as a wrong flag on the cycle after the write.

// File: rtl/pfi_pkg.sv
package pfi_pkg;
  localparam int NCH = 3;

  typedef struct packed {
    logic           load;
    logic           hit;
    logic [NCH-1:0] colWr;
    logic [NCH-1:0] ctWr;
  } pfiStrobe_t;
endpackage

// File: rtl/pfi_window.sv
module pfi_window #(
  parameter int POS_W   = 9,
  parameter bit FULL_EN = 1'b0
) (
  input  logic [POS_W-1:0] cnt,
  input  logic [POS_W-1:0] beginPos,
  input  logic [POS_W-1:0] endPos,
  output logic             active
);
  localparam logic [POS_W-1:0] FULL_CODE = {POS_W{1'b1}};

  always_comb begin
    if (beginPos == '0) begin
      active = 1'b0;
    end else if (FULL_EN && (beginPos == FULL_CODE)) begin
      active = 1'b1;
    end else if (beginPos <= endPos) begin
      active = (cnt >= beginPos) && (cnt < endPos);
    end else begin
      active = (cnt >= beginPos) || (cnt < endPos);
    end
  end
endmodule

// File: rtl/pfi_ctrl.sv
module pfi_ctrl #(
  parameter int POS_W  = 9,
  parameter int ADDR_W = 4,
  parameter int HB_RST = 0,
  parameter int HE_RST = 0,
  parameter int VB_RST = 270,
  parameter int VE_RST = 56
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hsyncIn,
  input  logic                 vsyncIn,
  input  logic                 pixValid,
  input  logic                 cfgWrEn,
  input  logic [ADDR_W-1:0]    cfgAddr,
  input  logic [POS_W-1:0]     cfgData,
  output pfi_pkg::pfiStrobe_t  strb
);
  localparam int NPOS     = 4;
  localparam int NAXIS    = 2;
  localparam int ADDR_COL = NPOS;
  localparam int ADDR_CT  = NPOS + pfi_pkg::NCH;
  localparam logic [POS_W-1:0] CNT_MAX = {POS_W{1'b1}};

  logic                        hsPrev, vsPrev;
  logic                        hsRise, vsRise;
  logic [POS_W-1:0]            pixCnt, lineCnt;
  logic [NPOS-1:0][POS_W-1:0]  posAct;
  logic [NAXIS-1:0][POS_W-1:0] axisCnt;
  logic [NAXIS-1:0]            axisAct;

  assign hsRise = hsyncIn & ~hsPrev;
  assign vsRise = vsyncIn & ~vsPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsPrev  <= 1'b0;
      vsPrev  <= 1'b0;
      pixCnt  <= '0;
      lineCnt <= '0;
    end else begin
      hsPrev <= hsyncIn;
      vsPrev <= vsyncIn;
      if (vsRise) begin
        pixCnt  <= '0;
        lineCnt <= '0;
      end else if (hsRise) begin
        pixCnt <= '0;
        if (lineCnt != CNT_MAX) lineCnt <= lineCnt + 1'b1;
      end else if (pixValid && (pixCnt != CNT_MAX)) begin
        pixCnt <= pixCnt + 1'b1;
      end
    end
  end

  function automatic logic [POS_W-1:0] posReset(int idx);
    case (idx)
      0:       return POS_W'(HB_RST);
      1:       return POS_W'(HE_RST);
      2:       return POS_W'(VB_RST);
      default: return POS_W'(VE_RST);
    endcase
  endfunction

  for (genvar gi = 0; gi < NPOS; gi++) begin : g_pos
    logic [POS_W-1:0] shReg, actReg;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shReg <= posReset(gi);
      end else if (cfgWrEn && (cfgAddr == ADDR_W'(gi))) begin
        shReg <= cfgData;
      end
    end
    always_ff @(posedge clk) begin
      if (!rstN) begin
        actReg <= posReset(gi);
      end else if (vsRise) begin
        actReg <= shReg;
      end
    end
    assign posAct[gi] = actReg;
  end

  assign axisCnt[0] = pixCnt;
  assign axisCnt[1] = lineCnt;

  for (genvar ax = 0; ax < NAXIS; ax++) begin : g_axis
    pfi_window #(
      .POS_W  (POS_W),
      .FULL_EN(ax == 0)
    ) uWin (
      .cnt     (axisCnt[ax]),
      .beginPos(posAct[2*ax]),
      .endPos  (posAct[2*ax+1]),
      .active  (axisAct[ax])
    );
  end

  always_comb begin
    strb.load = vsRise;
    strb.hit  = pixValid & (&axisAct);
    for (int c = 0; c < pfi_pkg::NCH; c++) begin
      strb.colWr[c] = cfgWrEn && (cfgAddr == ADDR_W'(ADDR_COL + c));
      strb.ctWr[c]  = cfgWrEn && (cfgAddr == ADDR_W'(ADDR_CT + c));
    end
  end
endmodule

// File: rtl/pfi_datapath.sv
module pfi_datapath #(
  parameter int NCH    = pfi_pkg::NCH,
  parameter int PIX_W  = 8,
  parameter int COL_W  = 4,
  parameter int CT_W   = 4,
  parameter int CT_MAX = 13,
  parameter int CT_OFS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pfi_pkg::pfiStrobe_t           strb,
  input  logic [LOW_W-1:0]              cfgLow,
  input  logic [NCH-1:0][PIX_W-1:0]     pixIn,
  output logic [NCH-1:0][PIX_W-1:0]     pixOut,
  output logic                          frameOut,
  output logic                          errFlag
);
  localparam int LOW_W = (COL_W > CT_W) ? COL_W : CT_W;
  localparam logic [CT_W-1:0] CT_LIMIT = CT_W'(CT_MAX);

  logic [NCH-1:0][PIX_W-1:0] pixNext;
  logic                      badWr;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [COL_W-1:0] colSh, colAct;
    logic [CT_W-1:0]  ctSh, ctAct, ctEff;
    logic [PIX_W-1:0] amp;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        colSh <= '0;
        ctSh  <= '0;
      end else begin
        if (strb.colWr[ch]) colSh <= cfgLow[COL_W-1:0];
        if (strb.ctWr[ch])  ctSh  <= cfgLow[CT_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        colAct <= '0;
        ctAct  <= '0;
      end else if (strb.load) begin
        colAct <= colSh;
        ctAct  <= ctSh;
      end
    end

    assign ctEff = (ctAct > CT_LIMIT) ? CT_LIMIT : ctAct;
    assign amp   = PIX_W'(colAct) * (PIX_W'(ctEff) + PIX_W'(CT_OFS));
    assign pixNext[ch] = strb.hit ? amp : pixIn[ch];
  end

  assign badWr = (|strb.ctWr) && (cfgLow[CT_W-1:0] > CT_LIMIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixOut   <= '0;
      frameOut <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      pixOut   <= pixNext;
      frameOut <= strb.hit;
      if (badWr) errFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/pic_frame_insert.sv
module pic_frame_insert #(
  parameter int POS_W  = 9,
  parameter int ADDR_W = 4,
  parameter int PIX_W  = 8,
  parameter int COL_W  = 4,
  parameter int CT_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsyncIn,
  input  logic              vsyncIn,
  input  logic              pixValid,
  input  logic [PIX_W-1:0]  rIn,
  input  logic [PIX_W-1:0]  gIn,
  input  logic [PIX_W-1:0]  bIn,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [POS_W-1:0]  cfgData,
  output logic [PIX_W-1:0]  rOut,
  output logic [PIX_W-1:0]  gOut,
  output logic [PIX_W-1:0]  bOut,
  output logic              frameOut,
  output logic              errFlag
);
  localparam int LOW_W = (COL_W > CT_W) ? COL_W : CT_W;

  pfi_pkg::pfiStrobe_t                 strb;
  logic [pfi_pkg::NCH-1:0][PIX_W-1:0]  pixIn, pixOut;

  assign pixIn = {bIn, gIn, rIn};
  assign rOut  = pixOut[0];
  assign gOut  = pixOut[1];
  assign bOut  = pixOut[2];

  pfi_ctrl #(
    .POS_W (POS_W),
    .ADDR_W(ADDR_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .hsyncIn (hsyncIn),
    .vsyncIn (vsyncIn),
    .pixValid(pixValid),
    .cfgWrEn (cfgWrEn),
    .cfgAddr (cfgAddr),
    .cfgData (cfgData),
    .strb    (strb)
  );

  pfi_datapath #(
    .PIX_W(PIX_W),
    .COL_W(COL_W),
    .CT_W (CT_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cfgLow  (cfgData[LOW_W-1:0]),
    .pixIn   (pixIn),
    .pixOut  (pixOut),
    .frameOut(frameOut),
    .errFlag (errFlag)
  );
endmodule

// File: rtl/pic_frame_insert_chk.sv
module pic_frame_insert_chk (
  input logic       clk,
  input logic       rstN,
  input logic       pixValid,
  input logic [7:0] rIn,
  input logic [7:0] gIn,
  input logic [7:0] bIn,
  input logic       cfgWrEn,
  input logic [3:0] cfgAddr,
  input logic [8:0] cfgData,
  input logic [7:0] rOut,
  input logic [7:0] gOut,
  input logic [7:0] bOut,
  input logic       frameOut,
  input logic       errFlag
);
  logic pastOk;
  logic badCode;

  always_ff @(posedge clk) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  assign badCode = cfgWrEn && (cfgAddr >= 4'd7) && (cfgAddr <= 4'd9) &&
                   (cfgData[3:0] > 4'd13);

  // R8: once raised the flag never drops while out of reset
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R8: an invalid contrast write raises the flag on the next cycle
  a_r8_err_on_bad_code: assert property (@(posedge clk) disable iff (!rstN)
    badCode |=> errFlag);

  // R8: the flag rises only after an invalid contrast write
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(badCode));

  // R6: outside the frame the video is delayed by one cycle and unchanged
  a_r6_outside_pass: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && !frameOut) |-> ({rOut, gOut, bOut} == $past({rIn, gIn, bIn})));

  // R6: frame colour only replaces a pixel that was valid
  a_r6_frame_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && frameOut) |-> $past(pixValid));
endmodule

bind pic_frame_insert pic_frame_insert_chk uChk (.*);

// File: tb/pic_frame_insert_test.sv
`timescale 1ns/1ps
module pic_frame_insert_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hsyncIn = 1'b0, vsyncIn = 1'b0, pixValid = 1'b0;
  logic [7:0] rIn = '0, gIn = '0, bIn = '0;
  logic       cfgWrEn = 1'b0;
  logic [3:0] cfgAddr = '0;
  logic [8:0] cfgData = '0;
  logic [7:0] rOut, gOut, bOut;
  logic       frameOut, errFlag;

  pic_frame_insert uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam int NPIX  = 12;
  localparam int NLINE = 6;

  int  sh[10];
  int  act[10];
  bit  mErr;

  typedef struct packed {
    logic [8:0]  hb, he, vb, ve;
    logic [3:0]  cr, cg, cb, kr, kg, kb;
    logic [15:0] tag;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{9'd2,   9'd6,  9'd1, 9'd4, 4'd15, 4'd8,  4'd1,  4'd13, 4'd0,  4'd5,  "R1"},
    '{9'd8,   9'd3,  9'd4, 9'd2, 4'd3,  4'd5,  4'd7,  4'd14, 4'd15, 4'd2,  "R3"},
    '{9'd511, 9'd0,  9'd2, 9'd5, 4'd9,  4'd2,  4'd12, 4'd3,  4'd7,  4'd1,  "R5"},
    '{9'd0,   9'd10, 9'd1, 9'd5, 4'd15, 4'd15, 4'd15, 4'd5,  4'd5,  4'd5,  "R4"},
    '{9'd3,   9'd9,  9'd0, 9'd5, 4'd15, 4'd15, 4'd15, 4'd5,  4'd5,  4'd5,  "R4"},
    '{9'd5,   9'd5,  9'd1, 9'd1, 4'd6,  4'd6,  4'd6,  4'd2,  4'd2,  4'd2,  "R2"},
    '{9'd1,   9'd11, 9'd1, 9'd5, 4'd15, 4'd15, 4'd15, 4'd14, 4'd15, 4'd13, "R7"}
  };

  task automatic modelReset();
    sh = '{0, 0, 270, 56, 0, 0, 0, 0, 0, 0};
    act = sh;
    mErr = 1'b0;
  endtask

  function automatic bit axisOn(int c, int b, int e, bit fullEn);
    if (b == 0) return 1'b0;
    if (fullEn && b == 511) return 1'b1;
    if (b <= e) return (c >= b) && (c < e);
    return (c >= b) || (c < e);
  endfunction

  task automatic check(bit ok, logic [15:0] tag, string what,
                       logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic wrReg(int addr, int data);
    cfgWrEn = 1'b1;
    cfgAddr = 4'(addr);
    cfgData = 9'(data);
    @(negedge clk);
    cfgWrEn = 1'b0;
    sh[addr] = (addr < 4) ? (data & 511) : (data & 15);
    if (addr >= 7 && (data & 15) > 13) mErr = 1'b1;
  endtask

  task automatic pulseV();
    vsyncIn = 1'b1;
    @(negedge clk);
    vsyncIn = 1'b0;
    @(negedge clk);
    act = sh;
  endtask

  task automatic runLines(int y0, int y1, logic [15:0] tag);
    for (int y = y0; y <= y1; y++) begin
      for (int x = 0; x < NPIX; x++) begin
        logic [7:0]  pin [3];
        logic [24:0] expV, gotV;
        bit          hit;
        pin[0] = 8'(x * 17 + y * 5);
        pin[1] = 8'(x * 3 + y * 29 + 1);
        pin[2] = 8'(255 - x - y * 7);
        pixValid = 1'b1;
        rIn = pin[0]; gIn = pin[1]; bIn = pin[2];
        @(negedge clk);
        hit = axisOn(x, act[0], act[1], 1'b1) && axisOn(y, act[2], act[3], 1'b0);
        expV[24] = hit;
        for (int c = 0; c < 3; c++) begin
          int k;
          k = (act[7+c] > 13) ? 13 : act[7+c];
          expV[(2-c)*8 +: 8] = hit ? 8'(act[4+c] * (k + 4)) : pin[c];
        end
        gotV = {frameOut, rOut, gOut, bOut};
        check(gotV == expV, tag, $sformatf("R6 pixel x=%0d y=%0d", x, y),
              32'(gotV), 32'(expV));
      end
      pixValid = 1'b0;
      hsyncIn = 1'b1;
      @(negedge clk);
      hsyncIn = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic checkErr(logic [15:0] tag);
    check(errFlag == mErr, tag, "R8 error flag", 32'(errFlag), 32'(mErr));
  endtask

  task automatic printSummary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired before the end of the run");
      printSummary();
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state at the outputs
    check({frameOut, rOut, gOut, bOut} == 25'd0, "R10", "outputs after reset",
          32'({frameOut, rOut, gOut, bOut}), 32'd0);
    checkErr("R10");
    // R10: default settings leave the video unchanged
    runLines(0, 2, "R10");

    // table of window settings, each checked over a full field
    for (int i = 0; i < NV; i++) begin
      wrReg(0, int'(VECS[i].hb)); wrReg(1, int'(VECS[i].he));
      wrReg(2, int'(VECS[i].vb)); wrReg(3, int'(VECS[i].ve));
      wrReg(4, int'(VECS[i].cr)); wrReg(5, int'(VECS[i].cg));
      wrReg(6, int'(VECS[i].cb)); wrReg(7, int'(VECS[i].kr));
      wrReg(8, int'(VECS[i].kg)); wrReg(9, int'(VECS[i].kb));
      @(negedge clk);
      checkErr("R8");
      pulseV();
      runLines(0, NLINE - 1, VECS[i].tag);
      checkErr("R8");
    end

    // R9: mid-field writes wait for the next vertical sync
    pulseV();
    runLines(0, 1, "R9");
    wrReg(0, 1); wrReg(1, 11); wrReg(2, 1); wrReg(3, 6);
    wrReg(4, 7); wrReg(5, 10); wrReg(6, 2);
    wrReg(7, 9); wrReg(8, 3);  wrReg(9, 0);
    runLines(2, NLINE - 1, "R9");
    pulseV();
    runLines(0, NLINE - 1, "R9");

    // R8: only reset clears the sticky flag
    checkErr("R8");
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    modelReset();
    @(negedge clk);
    checkErr("R8");
    runLines(0, 1, "R10");

    done = 1'b1;
    printSummary();
    $finish;
  end
endmodule